// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This block sits beside the decode stage of a five-stage in-order pipeline. Each cycle it takes the two source register numbers of the instruction being decoded. It compares them against the destinations that the execute and memory stages are about to write. For each operand it picks where the operand's value must come from: the register file, the execute-stage result or the memory-stage result. When one of the sources depends on a load that has not yet left execute, the value cannot be bypassed in time. In that case the unit asks for one bubble into execute and freezes fetch and decode.

The register file writes in the first half of a cycle and reads in the second half. A value that is being written back is therefore already visible to decode, so the writeback stage needs no comparator. Operands are read early and all results retire in order in the last stage. For that reason only read-after-write dependences are tracked. The clock and reset inputs serve only to time the embedded property checks. The select and interlock outputs are purely combinational.

Top module: `raw_bypass_unit`

## Requirements
- R1: With no pending writer that matches, both operand selects read 2'b00 (register file) and the interlock outputs are 0.
- R2: A used, non-zero source equal to the execute-stage destination, with that stage's write enable set and its load flag clear, gives select 2'b01 (execute result) and no stall.
- R3: A used, non-zero source that matches only the memory-stage destination with its write enable set gives select 2'b10 (memory result), whether or not that instruction is a load.
- R4: When the execute and memory stages both match a source, the select is 2'b01: the younger writer wins.
- R5: Source register 0 never matches any stage: its select is 2'b00 and it never causes a stall.
- R6: A source whose use flag is 0 gets select 2'b00 and never causes a stall, even if its register number matches a writer.
- R7: A stage whose write enable is 0 never matches, whatever its destination number.
- R8: A used, non-zero source that matches the execute-stage destination while that stage has write enable and load flag set drives stall, bubbleEx and holdFront all to 1.
- R9: stall is 1 only in the case of R8, and bubbleEx and holdFront always equal stall.
- R10: The two operands are resolved independently: each select depends only on its own source number and use flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the embedded checks |
| rstN | input | 1 | Active-low reset that disables the checks |
| srcAReg | input | REG_W | First source register number of the decode instruction |
| srcAUsed | input | 1 | First source is actually read |
| srcBReg | input | REG_W | Second source register number |
| srcBUsed | input | 1 | Second source is actually read |
| exDst | input | REG_W | Destination of the execute-stage instruction |
| exWrEn | input | 1 | Execute-stage instruction writes a register |
| exIsLoad | input | 1 | Execute-stage instruction is a load |
| memDst | input | REG_W | Destination of the memory-stage instruction |
| memWrEn | input | 1 | Memory-stage instruction writes a register |
| fwdSelA | output | 2 | Operand A source: 00 register file, 01 execute, 10 memory |
| fwdSelB | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Load-use interlock active |
| bubbleEx | output | 1 | Inject a bubble into execute |
| holdFront | output | 1 | Freeze fetch and decode |

## Verification
Directed patterns separate the stage that matches (execute only, memory only, both) so that the priority order shows up in the select codes. Register 0, a cleared use flag and a cleared write enable are each paired with a destination that would otherwise match, which proves that each mask works on its own. A load sitting in execute is contrasted with the same load one stage later: the first must raise the interlock, the second must bypass from memory. Mixed cases give the two operands different answers in the same cycle, which exposes any crosstalk between them.

// File: rtl/raw_bypass_pkg.sv
package raw_bypass_pkg;

  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_EX  = 2'b01,
    SEL_MEM = 2'b10
  } fwdSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] exHit;
    logic [NUM_SRC-1:0] memHit;
    logic [NUM_SRC-1:0] loadHit;
  } hitVec_t;

  typedef struct packed {
    logic stall;
    logic bubbleEx;
    logic holdFront;
  } ctrlStrobes_t;

endpackage

// File: rtl/raw_cmp_path.sv
module raw_cmp_path
  import raw_bypass_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0][REG_W-1:0] srcReg,
  input  logic [NUM_SRC-1:0]            srcUsed,
  input  logic [REG_W-1:0]              exDst,
  input  logic                          exWrEn,
  input  logic                          exIsLoad,
  input  logic [REG_W-1:0]              memDst,
  input  logic                          memWrEn,
  output hitVec_t                       hits
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [NUM_SRC-1:0] live;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign live[s]         = srcUsed[s] && (srcReg[s] != ZERO_REG);
    assign hits.exHit[s]   = live[s] && exWrEn  && (exDst  == srcReg[s]);
    assign hits.memHit[s]  = live[s] && memWrEn && (memDst == srcReg[s]);
    assign hits.loadHit[s] = hits.exHit[s] && exIsLoad;

    // R7
    ex_hit_needs_wren_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hits.exHit[s] || hits.memHit[s]) |-> (exWrEn || memWrEn));

    // R5
    zero_reg_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
      (srcReg[s] == ZERO_REG) |-> !(hits.exHit[s] || hits.memHit[s]));
  end

endmodule

// File: rtl/raw_ctrl.sv
module raw_ctrl
  import raw_bypass_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  hitVec_t                 hits,
  input  logic [NUM_SRC-1:0]      srcUsed,
  output logic [NUM_SRC-1:0][1:0] fwdSel,
  output ctrlStrobes_t            strobes
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sel
    always_comb begin
      if (hits.exHit[s])       fwdSel[s] = SEL_EX;
      else if (hits.memHit[s]) fwdSel[s] = SEL_MEM;
      else                     fwdSel[s] = SEL_RF;
    end

    // R4
    mem_sel_only_without_ex_chk: assert property (@(posedge clk) disable iff (!rstN)
      (fwdSel[s] == SEL_MEM) |-> (hits.memHit[s] && !hits.exHit[s]));

    // R6
    unused_src_rf_chk: assert property (@(posedge clk) disable iff (!rstN)
      !srcUsed[s] |-> (fwdSel[s] == SEL_RF));
  end

  logic loadUse;
  assign loadUse = |hits.loadHit;

  always_comb begin
    strobes.stall     = loadUse;
    strobes.bubbleEx  = loadUse;
    strobes.holdFront = loadUse;
  end

  // R8
  stall_needs_ex_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stall |-> (|hits.exHit));

endmodule

// File: rtl/raw_bypass_unit.sv
module raw_bypass_unit
  import raw_bypass_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] srcAReg,
  input  logic             srcAUsed,
  input  logic [REG_W-1:0] srcBReg,
  input  logic             srcBUsed,
  input  logic [REG_W-1:0] exDst,
  input  logic             exWrEn,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] memDst,
  input  logic             memWrEn,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB,
  output logic             stall,
  output logic             bubbleEx,
  output logic             holdFront
);

  logic [NUM_SRC-1:0][REG_W-1:0] srcReg;
  logic [NUM_SRC-1:0]            srcUsed;
  logic [NUM_SRC-1:0][1:0]       fwdSel;
  hitVec_t                       hits;
  ctrlStrobes_t                  strobes;

  assign srcReg  = {srcBReg, srcAReg};
  assign srcUsed = {srcBUsed, srcAUsed};

  raw_cmp_path #(.REG_W(REG_W)) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .srcReg   (srcReg),
    .srcUsed  (srcUsed),
    .exDst    (exDst),
    .exWrEn   (exWrEn),
    .exIsLoad (exIsLoad),
    .memDst   (memDst),
    .memWrEn  (memWrEn),
    .hits     (hits)
  );

  raw_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hits    (hits),
    .srcUsed (srcUsed),
    .fwdSel  (fwdSel),
    .strobes (strobes)
  );

  assign fwdSelA   = fwdSel[0];
  assign fwdSelB   = fwdSel[1];
  assign stall     = strobes.stall;
  assign bubbleEx  = strobes.bubbleEx;
  assign holdFront = strobes.holdFront;

  // R9
  interlock_outputs_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bubbleEx == stall) && (holdFront == stall));

  // R8
  stall_needs_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (exWrEn && exIsLoad));

endmodule

// File: tb/test_raw_bypass_unit.sv
module test_raw_bypass_unit;

  localparam int REG_W = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [REG_W-1:0] srcAReg = '0, srcBReg = '0, exDst = '0, memDst = '0;
  logic             srcAUsed = 1'b0, srcBUsed = 1'b0;
  logic             exWrEn = 1'b0, exIsLoad = 1'b0, memWrEn = 1'b0;
  logic [1:0]       fwdSelA, fwdSelB;
  logic             stall, bubbleEx, holdFront;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #2.5 clk = ~clk;

  raw_bypass_unit #(.REG_W(REG_W)) i_raw_bypass_unit (
    .clk(clk), .rstN(rstN),
    .srcAReg(srcAReg), .srcAUsed(srcAUsed),
    .srcBReg(srcBReg), .srcBUsed(srcBUsed),
    .exDst(exDst), .exWrEn(exWrEn), .exIsLoad(exIsLoad),
    .memDst(memDst), .memWrEn(memWrEn),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .stall(stall), .bubbleEx(bubbleEx), .holdFront(holdFront)
  );

  task automatic check(input string req, input int actual, input int expected);
    checkCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic apply(input int aR, input bit aU, input int bR, input bit bU,
                       input int exD, input bit exW, input bit exL,
                       input int memD, input bit memW);
    @(negedge clk);
    srcAReg = aR[REG_W-1:0]; srcAUsed = aU;
    srcBReg = bR[REG_W-1:0]; srcBUsed = bU;
    exDst = exD[REG_W-1:0]; exWrEn = exW; exIsLoad = exL;
    memDst = memD[REG_W-1:0]; memWrEn = memW;
    #1;
  endtask

  task automatic checkAll(input string req, input int sa, input int sb, input int st);
    check({req, " selA"}, fwdSelA, sa);
    check({req, " selB"}, fwdSelB, sb);
    check({req, " stall"}, stall, st);
    check({req, " bubbleEx"}, bubbleEx, st);
    check({req, " holdFront"}, holdFront, st);
  endtask

  task automatic t_reset_state;
    #1;
    checkAll("R1 reset", 0, 0, 0);
  endtask

  task automatic t_no_match;
    apply(3, 1, 4, 1, 7, 1, 0, 9, 1);
    checkAll("R1 nomatch", 0, 0, 0);
  endtask

  task automatic t_ex_forward;
    apply(6, 1, 2, 1, 6, 1, 0, 11, 1);
    checkAll("R2 exA", 1, 0, 0);
    apply(2, 1, 6, 1, 6, 1, 0, 11, 1);
    checkAll("R2 exB", 0, 1, 0);
  endtask

  task automatic t_mem_forward;
    apply(12, 1, 13, 1, 5, 1, 0, 12, 1);
    checkAll("R3 memA", 2, 0, 0);
    apply(13, 1, 12, 1, 12, 0, 1, 12, 1);
    checkAll("R3 memB exWrEn off", 0, 2, 0);
  endtask

  task automatic t_nearest;
    apply(8, 1, 8, 1, 8, 1, 0, 8, 1);
    checkAll("R4 both stages", 1, 1, 0);
  endtask

  task automatic t_zero_reg;
    apply(0, 1, 0, 1, 0, 1, 1, 0, 1);
    checkAll("R5 zero reg", 0, 0, 0);
  endtask

  task automatic t_unused;
    apply(9, 0, 9, 0, 9, 1, 1, 9, 1);
    checkAll("R6 unused", 0, 0, 0);
  endtask

  task automatic t_wren_low;
    apply(14, 1, 15, 1, 14, 0, 1, 15, 0);
    checkAll("R7 wren low", 0, 0, 0);
  endtask

  task automatic t_load_use;
    apply(20, 1, 3, 1, 20, 1, 1, 3, 1);
    check("R8 loaduse stall", stall, 1);
    check("R9 bubbleEx", bubbleEx, 1);
    check("R9 holdFront", holdFront, 1);
    check("R10 selB", fwdSelB, 2);
    apply(3, 1, 20, 1, 20, 1, 1, 0, 0);
    check("R8 loaduse on B", stall, 1);
  endtask

  task automatic t_load_in_mem;
    apply(21, 1, 22, 1, 1, 1, 0, 21, 1);
    checkAll("R8 load one stage later", 2, 0, 0);
    apply(21, 1, 22, 0, 22, 1, 1, 5, 1);
    checkAll("R9 load with no used match", 0, 0, 0);
  endtask

  task automatic t_mixed;
    apply(17, 1, 18, 1, 17, 1, 0, 18, 1);
    checkAll("R10 mixed", 1, 2, 0);
    apply(18, 1, 17, 1, 17, 1, 0, 18, 1);
    checkAll("R10 swapped", 2, 1, 0);
  endtask

  initial begin
    t_reset_state();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_no_match();
    t_ex_forward();
    t_mem_forward();
    t_nearest();
    t_zero_reg();
    t_unused();
    t_wren_low();
    t_load_use();
    t_load_in_mem();
    t_mixed();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule